// File: doc/BRIEF.md
# PHY Register Handshake Responder

This block is the PHY-side end of an indirect register channel. A host drives a 20-bit control word whose low 16 bits carry either an address or data, and whose upper four bits are strobes. The responder latches an address or a data word on the two capture strobes. It commits the latched data into a small register array on the write strobe. On the read strobe it presents the addressed register on a 16-bit status data bus. An acknowledge bit completes every step: it follows the level of the strobe, delayed by a set number of cycles on both edges, so the host has to wait for ack high and then for ack low.

The array holds four 16-bit registers, at 0x1002, 0x1003, 0x1005 and 0x100D. Register 0x1005 carries receiver override controls, and their two bits also leave the block as pins. Register 0x100D is a read-only flag register whose bit 0 reports that the receiver output is valid. The parameter `ACK_DLY` sets the acknowledge latency, so a host's polling limits can be tested against a slow responder.

Top module: `phy_reg_responder`

## Requirements
- R1: After synchronous reset, `stat_ack` is 0, `stat_data` is 0x0000, and both override outputs are 0.
- R2: A fresh strobe with only `ctl_word[16]` set latches `ctl_word[15:0]` as the target address.
- R3: A fresh strobe with only `ctl_word[17]` set latches `ctl_word[15:0]` as the write data. The latched data stays until the next such strobe, so several writes can reuse it.
- R4: A fresh strobe with only `ctl_word[18]` set stores the latched data into the register at the latched address, if that register is writable (0x1002, 0x1003, 0x1005).
- R5: A fresh strobe with only `ctl_word[19]` set loads `stat_data` with the register at the latched address. `stat_data` then holds that value until the next accepted read.
- R6: `stat_ack` rises `ACK_DLY` clock edges after the first edge that samples an accepted strobe. It stays high while any strobe bit remains set. It falls `ACK_DLY` edges after the first edge that samples all four strobe bits at zero.
- R7: A strobe counts as fresh only when all strobe bits were zero on the previous edge and the responder is idle (ack low, no countdown running). A strobe that appears while ack is high is ignored and gives no acknowledge, even after ack has fallen.
- R8: If more than one strobe bit is set, the responder takes no action, and `stat_ack` stays low.
- R9: A write to an address outside the array changes nothing. A read from such an address returns 0x0000.
- R10: Register 0x100D always reads 0x0001 (bit 0 is the receiver-output-valid flag), and writes to it are dropped.
- R11: `rx_data_en_ovrd` follows bit 5 of register 0x1005, and `rx_pll_en_ovrd` follows bit 3 of the same register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_word | input | 20 | Host control word: [15:0] address or data, [16] capture address, [17] capture data, [18] write, [19] read |
| stat_ack | output | 1 | Acknowledge, follows the strobe level with latency |
| stat_data | output | 16 | Data from the last accepted read |
| rx_data_en_ovrd | output | 1 | Bit 5 of register 0x1005 |
| rx_pll_en_ovrd | output | 1 | Bit 3 of register 0x1005 |

## Verification
A new strobe can arrive in the same cycle as the acknowledge release countdown. This happens when the host drops a strobe and raises the next one before ack has fallen. The bench provokes this by raising a capture-address strobe for a second address one cycle after dropping the first. It judges the result in two ways: ack must fall and stay low, and a following read must return the register at the first address. A capture and a data strobe raised together form the second collision. That case is judged by ack staying low and by unchanged latched address and data, as later reads and writes reveal.

// File: rtl/phyhs_pkg.sv
package phyhs_pkg;

    localparam int DATA_W   = 16;
    localparam int STB_W    = 4;
    localparam int CTL_W    = DATA_W + STB_W;
    localparam int NUM_REGS = 4;

    typedef logic [DATA_W-1:0] word_t;

    // Field order matches the control word bit positions (MSB first).
    typedef struct packed {
        logic  rd;        // bit 19
        logic  wr;        // bit 18
        logic  cap_dat;   // bit 17
        logic  cap_adr;   // bit 16
        word_t payload;   // bits 15:0
    } ctl_t;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_CAP_ADDR,
        OP_CAP_DATA,
        OP_WRITE,
        OP_READ
    } op_e;

    typedef enum logic [1:0] {
        T_IDLE,
        T_RISE,
        T_HIGH,
        T_FALL
    } tstate_e;

    localparam word_t OVRD_ADDR     = 16'h1005;
    localparam int    OVRD_DATA_BIT = 5;
    localparam int    OVRD_PLL_BIT  = 3;

    function automatic word_t slot_addr(int i);
        case (i)
            0:       return 16'h1002;
            1:       return 16'h1003;
            2:       return 16'h1005;
            default: return 16'h100D;
        endcase
    endfunction

    function automatic logic slot_writable(int i);
        return slot_addr(i) != 16'h100D;
    endfunction

    function automatic word_t slot_reset(int i);
        return (slot_addr(i) == 16'h100D) ? 16'h0001 : 16'h0000;
    endfunction

    // Exactly one strobe bit selects an operation; anything else is no-op.
    function automatic op_e decode_op(logic [STB_W-1:0] s);
        case (s)
            4'b0001: return OP_CAP_ADDR;
            4'b0010: return OP_CAP_DATA;
            4'b0100: return OP_WRITE;
            4'b1000: return OP_READ;
            default: return OP_NONE;
        endcase
    endfunction

endpackage

// File: rtl/phyhs_strobe_decode.sv
module phyhs_strobe_decode
    import phyhs_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [STB_W-1:0] stb,
    output op_e              fresh_op,
    output logic             stb_any
);

    logic [STB_W-1:0] stb_prev;

    always_ff @(posedge clk) begin
        if (rst) stb_prev <= '0;
        else     stb_prev <= stb;
    end

    // Only a transition out of all-zero counts as a rising strobe.
    always_comb begin
        stb_any  = |stb;
        fresh_op = OP_NONE;
        if (stb_prev == '0)
            fresh_op = decode_op(stb);
    end

endmodule

// File: rtl/phyhs_ack_timer.sv
module phyhs_ack_timer
    import phyhs_pkg::*;
#(
    parameter int ACK_DLY = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic stb_any,
    output logic ack,
    output logic idle
);

    localparam int CNT_W = (ACK_DLY > 1) ? $clog2(ACK_DLY) : 1;
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(ACK_DLY - 1);

    tstate_e          state;
    logic [CNT_W-1:0] cnt;
    logic             ack_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= T_IDLE;
            cnt   <= '0;
            ack_q <= 1'b0;
        end else begin
            case (state)
                T_IDLE: if (start) begin
                    state <= T_RISE;
                    cnt   <= CNT_LOAD;
                end
                T_RISE: if (cnt == '0) begin
                    state <= T_HIGH;
                    ack_q <= 1'b1;
                end else begin
                    cnt <= cnt - 1'b1;
                end
                T_HIGH: if (!stb_any) begin
                    state <= T_FALL;
                    cnt   <= CNT_LOAD;
                end
                T_FALL: if (cnt == '0) begin
                    state <= T_IDLE;
                    ack_q <= 1'b0;
                end else begin
                    cnt <= cnt - 1'b1;
                end
                default: state <= T_IDLE;
            endcase
        end
    end

    assign ack  = ack_q;
    assign idle = (state == T_IDLE);

    // R6: ack is held while the strobe is still asserted
    a_r6_hold_while_strobe: assert property (@(posedge clk) disable iff (rst)
        (state == T_HIGH && stb_any) |=> ack_q);

    // R6: no acknowledge without a handshake in progress
    a_r6_low_when_idle: assert property (@(posedge clk) disable iff (rst)
        (state == T_IDLE) |-> !ack_q);

endmodule

// File: rtl/phyhs_regs.sv
module phyhs_regs
    import phyhs_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  op_e   op,
    input  word_t payload,
    output word_t rd_data,
    output word_t ovrd_word
);

    word_t addr_q;
    word_t wdata_q;
    word_t rd_q;
    word_t rd_mux;
    logic [NUM_REGS-1:0]             hit;
    logic [NUM_REGS-1:0][DATA_W-1:0] slot_val;

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_slot
        assign hit[g] = (addr_q == slot_addr(g));
        if (slot_writable(g)) begin : g_rw
            word_t val;
            always_ff @(posedge clk) begin
                if (rst)                          val <= slot_reset(g);
                else if (op == OP_WRITE && hit[g]) val <= wdata_q;
            end
            assign slot_val[g] = val;
        end else begin : g_ro
            assign slot_val[g] = slot_reset(g);
        end
    end

    always_comb begin
        rd_mux    = '0;
        ovrd_word = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (hit[i])                   rd_mux    = slot_val[i];
            if (slot_addr(i) == OVRD_ADDR) ovrd_word = slot_val[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            wdata_q <= '0;
            rd_q    <= '0;
        end else begin
            case (op)
                OP_CAP_ADDR: addr_q  <= payload;
                OP_CAP_DATA: wdata_q <= payload;
                OP_READ:     rd_q    <= rd_mux;
                default: ;
            endcase
        end
    end

    assign rd_data = rd_q;

    // R5: status data only changes on an accepted read
    a_r5_rd_hold: assert property (@(posedge clk) disable iff (rst)
        (op != OP_READ) |=> $stable(rd_q));

    // R9: a write that misses every slot leaves the array untouched
    a_r9_miss_dropped: assert property (@(posedge clk) disable iff (rst)
        (op == OP_WRITE && hit == '0) |=> $stable(slot_val));

endmodule

// File: rtl/phy_reg_responder.sv
module phy_reg_responder
    import phyhs_pkg::*;
#(
    parameter int ACK_DLY = 3
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [19:0] ctl_word,
    output logic        stat_ack,
    output logic [15:0] stat_data,
    output logic        rx_data_en_ovrd,
    output logic        rx_pll_en_ovrd
);

    ctl_t             ctl;
    logic [STB_W-1:0] strobes;
    op_e              fresh_op;
    op_e              fire_op;
    logic             stb_any;
    logic             idle;
    logic             start;
    word_t            ovrd_word;

    assign ctl     = ctl_t'(ctl_word);
    assign strobes = {ctl.rd, ctl.wr, ctl.cap_dat, ctl.cap_adr};

    phyhs_strobe_decode u_dec (
        .clk      (clk),
        .rst      (rst),
        .stb      (strobes),
        .fresh_op (fresh_op),
        .stb_any  (stb_any)
    );

    assign fire_op = idle ? fresh_op : OP_NONE;
    assign start   = (fire_op != OP_NONE);

    phyhs_ack_timer #(.ACK_DLY(ACK_DLY)) u_tmr (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .stb_any (stb_any),
        .ack     (stat_ack),
        .idle    (idle)
    );

    phyhs_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .op        (fire_op),
        .payload   (ctl.payload),
        .rd_data   (stat_data),
        .ovrd_word (ovrd_word)
    );

    assign rx_data_en_ovrd = ovrd_word[OVRD_DATA_BIT];
    assign rx_pll_en_ovrd  = ovrd_word[OVRD_PLL_BIT];

    // R8: several strobe bits at once never start a handshake
    a_r8_multi_no_start: assert property (@(posedge clk) disable iff (rst)
        ($countones(strobes) > 1) |-> !start);

    // R7: nothing is accepted while the acknowledge is up
    a_r7_no_fire_under_ack: assert property (@(posedge clk) disable iff (rst)
        stat_ack |-> (fire_op == OP_NONE));

endmodule

// File: tb/phy_reg_responder_test.sv
module phy_reg_responder_test;

    localparam int D = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [19:0] ctl = '0;
    logic        stat_ack;
    logic [15:0] stat_data;
    logic        ovrd_data, ovrd_pll;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [15:0] m1002 = 16'h0, m1003 = 16'h0, m1005 = 16'h0;

    always #5 clk = ~clk;

    phy_reg_responder #(.ACK_DLY(D)) uut (
        .clk             (clk),
        .rst             (rst),
        .ctl_word        (ctl),
        .stat_ack        (stat_ack),
        .stat_data       (stat_data),
        .rx_data_en_ovrd (ovrd_data),
        .rx_pll_en_ovrd  (ovrd_pll)
    );

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_ack(bit lvl, output bit ok);
        ok = 1'b0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (stat_ack == lvl) begin
                ok = 1'b1;
                break;
            end
        end
    endtask

    // One full strobe/ack/release exchange; call at a falling edge.
    task automatic hs(logic [3:0] s, logic [15:0] d);
        bit ok;
        ctl = {s, d};
        wait_ack(1'b1, ok);
        chk(ok, "R6 ack rise", {31'b0, stat_ack}, 1);
        ctl = {4'b0000, d};
        wait_ack(1'b0, ok);
        chk(ok, "R6 ack fall", {31'b0, stat_ack}, 0);
    endtask

    task automatic phy_write(logic [15:0] a, logic [15:0] d);
        hs(4'b0001, a);
        hs(4'b0010, d);
        hs(4'b0100, 16'h0000);
        case (a)
            16'h1002: m1002 = d;
            16'h1003: m1003 = d;
            16'h1005: m1005 = d;
            default: ;
        endcase
    endtask

    task automatic phy_read(logic [15:0] a, output logic [15:0] r);
        hs(4'b0001, a);
        hs(4'b1000, 16'h0000);
        r = stat_data;
    endtask

    function automatic logic [15:0] model(logic [15:0] a);
        case (a)
            16'h1002: return m1002;
            16'h1003: return m1003;
            16'h1005: return m1005;
            16'h100D: return 16'h0001;
            default:  return 16'h0000;
        endcase
    endfunction

    initial begin
        #2_000_000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] r;
        logic [15:0] addrs [7] = '{16'h1002, 16'h1003, 16'h1005, 16'h100D,
                                   16'h1000, 16'hFFFF, 16'h1004};
        logic [15:0] pats  [5] = '{16'hA5A5, 16'h5A5A, 16'hFFFF, 16'h0000, 16'h1234};

        // R1: reset state
        repeat (3) @(negedge clk);
        chk(stat_ack == 1'b0, "R1 ack", {31'b0, stat_ack}, 0);
        chk(stat_data == 16'h0, "R1 data", {16'b0, stat_data}, 0);
        chk({ovrd_data, ovrd_pll} == 2'b00, "R1 ovrd", {30'b0, ovrd_data, ovrd_pll}, 0);
        rst = 1'b0;
        @(negedge clk);

        // R6: exact acknowledge latency on both edges
        ctl = {4'b0001, 16'h1002};
        repeat (D) @(negedge clk);
        chk(stat_ack == 1'b0, "R6 early rise", {31'b0, stat_ack}, 0);
        @(negedge clk);
        chk(stat_ack == 1'b1, "R6 rise", {31'b0, stat_ack}, 1);
        repeat (4) @(negedge clk);
        chk(stat_ack == 1'b1, "R6 hold", {31'b0, stat_ack}, 1);
        ctl = {4'b0000, 16'h1002};
        repeat (D) @(negedge clk);
        chk(stat_ack == 1'b1, "R6 early fall", {31'b0, stat_ack}, 1);
        @(negedge clk);
        chk(stat_ack == 1'b0, "R6 fall", {31'b0, stat_ack}, 0);

        // R2 R3 R4 R9 R10 R11: write/read sweep over addresses and patterns
        foreach (addrs[i]) begin
            foreach (pats[j]) begin
                phy_write(addrs[i], pats[j]);
                phy_read(addrs[i], r);
                if (addrs[i] == 16'h100D)
                    chk(r == 16'h0001, "R10 read-only", {16'b0, r}, 32'h1);
                else if (model(addrs[i]) == 16'h0 && addrs[i][3:0] inside {4'h0, 4'hF, 4'h4})
                    chk(r == 16'h0, "R9 unmapped", {16'b0, r}, 0);
                else
                    chk(r == model(addrs[i]), "R4 write-read (R2 R3)", {16'b0, r}, {16'b0, model(addrs[i])});
                if (addrs[i] == 16'h1005) begin
                    chk(ovrd_data == pats[j][5], "R11 data override", {31'b0, ovrd_data}, {31'b0, pats[j][5]});
                    chk(ovrd_pll == pats[j][3], "R11 pll override", {31'b0, ovrd_pll}, {31'b0, pats[j][3]});
                end
            end
        end

        // R3: latched data reused by writes to two addresses
        hs(4'b0010, 16'h3C3C);
        hs(4'b0001, 16'h1002);
        hs(4'b0100, 16'h0000);
        hs(4'b0001, 16'h1003);
        hs(4'b0100, 16'h0000);
        m1002 = 16'h3C3C;
        m1003 = 16'h3C3C;
        phy_read(16'h1002, r);
        chk(r == 16'h3C3C, "R3 reuse a", {16'b0, r}, 32'h3C3C);
        phy_read(16'h1003, r);
        chk(r == 16'h3C3C, "R3 reuse b", {16'b0, r}, 32'h3C3C);

        // R5: status data held across non-read handshakes
        hs(4'b0001, 16'h1005);
        hs(4'b0010, 16'hBEEF);
        chk(stat_data == 16'h3C3C, "R5 hold", {16'b0, stat_data}, 32'h3C3C);

        // R8: two strobes together do nothing
        ctl = {4'b0011, 16'h1003};
        repeat (2 * D + 4) @(negedge clk);
        chk(stat_ack == 1'b0, "R8 no ack", {31'b0, stat_ack}, 0);
        ctl = '0;
        repeat (3) @(negedge clk);
        hs(4'b1000, 16'h0000);
        chk(stat_data == model(16'h1005), "R8 addr kept", {16'b0, stat_data}, {16'b0, model(16'h1005)});
        hs(4'b0100, 16'h0000);
        m1005 = 16'hBEEF;
        phy_read(16'h1005, r);
        chk(r == 16'hBEEF, "R8 data kept", {16'b0, r}, 32'hBEEF);

        // R7: strobe raised during the release countdown is ignored
        phy_write(16'h1005, 16'h0028);
        phy_write(16'h1003, 16'h7777);
        ctl = {4'b0001, 16'h1005};
        begin
            bit ok;
            wait_ack(1'b1, ok);
            chk(ok, "R7 setup", {31'b0, stat_ack}, 1);
        end
        ctl = {4'b0000, 16'h1005};
        @(negedge clk);
        ctl = {4'b0001, 16'h1003};
        chk(stat_ack == 1'b1, "R7 still high", {31'b0, stat_ack}, 1);
        repeat (2 * D + 4) @(negedge clk);
        chk(stat_ack == 1'b0, "R7 ignored", {31'b0, stat_ack}, 0);
        ctl = '0;
        repeat (3) @(negedge clk);
        hs(4'b1000, 16'h0000);
        chk(stat_data == 16'h0028, "R7 first addr kept", {16'b0, stat_data}, 32'h0028);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule